// File: doc/BRIEF.md
# Polyphase Rational FIR Resampler

This block changes the sample rate of a single real fixed-point stream by the rational ratio UP/DOWN. The output sequence is the one that would result from inserting UP-1 zeros after every input sample, running the padded stream through a lowpass FIR, and then keeping one sample in every DOWN. The zero-padded stream is never built. A phase counter picks, for each output, the polyphase branch whose coefficients line up with real input samples. Only those taps are multiplied, against a short delay line that runs at the input rate.

Input samples arrive with data_i/valid_i and are taken only while ready_o is high. ready_o is derived from registered state alone, so an upstream source can watch it, or can simply space its samples ceil(UP/DOWN) cycles apart. Results come out on data_o/valid_o through a one-entry holding register. With USE_REQ set, a held result leaves only on a cycle where req_i is high. With USE_REQ clear, req_i is ignored and each result appears on the cycle after it is computed. The ratio, the tap count and the coefficient set are fixed when the design is elaborated.

Top module: `rate_conv_fir`

## Requirements
- R1: Output k equals the sum over taps t = p, p+UP, p+2*UP, ... (t < NTAPS) of COEFS[t] times input number q-(t-p)/UP, where k*DOWN = q*UP + p. Input numbers below zero count as zero. Outputs appear in increasing k.
- R2: After reset the delay line holds zeros, valid_o is low and ready_o is high. The first accepted input is input number 0.
- R3: data_i is taken on a rising edge only when valid_i and ready_o are both high. A sample offered while ready_o is low is dropped and never enters any output.
- R4: A source that ignores ready_o and offers a sample once every ceil(UP/DOWN) cycles always finds ready_o high. This means every other cycle for 3/2 and every cycle for 2/3.
- R5: With USE_REQ clear, UP >= DOWN and valid_i held high, valid_o is high on every cycle once the stream has started.
- R6: With USE_REQ set, valid_o is high only on cycles with req_i high and a result held. A held result keeps its value on data_o until it is taken.
- R7: With USE_REQ clear, valid_o is high exactly on the cycle after a result is computed and low otherwise. For UP=2, DOWN=3 and input on every cycle, valid_o is high on 20 of any 30 consecutive steady-state cycles.
- R8: Coefficients are signed CW-bit values with all bits fractional. The full-precision sum is shifted right by CW bits, rounding toward minus infinity, and only its low DW bits are kept as a signed result, so overflow wraps.
- R9: Once the source stops and the output is drained, N accepted inputs have produced exactly ceil(N*UP/DOWN) outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| data_i | input | DW | Signed input sample |
| valid_i | input | 1 | data_i holds a sample |
| ready_o | output | 1 | A sample offered this cycle is taken |
| req_i | input | 1 | Output request, used only when USE_REQ is set |
| data_o | output | DW | Signed resampled sample |
| valid_o | output | 1 | data_o carries a new sample |

## Verification
Three instances are driven: a 3/2 converter without request, a 2/3 converter fed every cycle, and a 3/2 converter with request. Every valid output is compared in order against a zero-stuff, filter and decimate model. The input stream cycles through a pseudo-random ramp, alternating full-scale values, a constant full-scale value and small negative values. The full-scale sections force wrap-around and the small negative values expose floor rounding against truncation. In the request instance, valid_i is held high while ready_o toggles, so dropped samples carry distinct values and would corrupt the comparison if they leaked in. A long request gap checks that a held sample is neither lost nor overwritten. Output-density windows distinguish continuous output (3/2) from the two-in-three pattern (2/3), and a final output count catches samples that are stuck or duplicated.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  // integer ceiling of a/b for positive operands
  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  // bits needed to hold values 0 .. n-1
  function automatic int span_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rfr_phase_ctrl.sv
module rfr_phase_ctrl #(
  parameter int UP      = 3,
  parameter int DOWN    = 2,
  parameter int PW      = 3,
  parameter int USE_REQ = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          hold_v,
  input  logic          drain,
  output logic          ready_o,
  output logic          take,
  output logic          fire,
  output logic [PW-1:0] phase_q
);
  localparam logic [PW-1:0] UP_P = PW'(UP);
  localparam logic [PW-1:0] DN_P = PW'(DOWN);
  localparam logic [PW:0]   UP_W = (PW+1)'(UP);

  logic          below;      // current input still owes an output
  logic          slot_free;  // holding register can take a result now
  logic          slot_sure;  // slot free without looking at req_i
  logic [PW:0]   reach;      // phase after this cycle's output
  logic [PW-1:0] phase_nx;

  assign below     = phase_q < UP_P;
  assign slot_free = !hold_v || drain;
  assign slot_sure = (USE_REQ == 0) || !hold_v;
  assign reach     = {1'b0, phase_q} + (PW+1)'(DOWN);
  assign fire      = below && slot_free;
  assign ready_o   = !below || ((reach >= UP_W) && slot_sure);
  assign take      = valid_i && ready_o;

  always_comb begin
    phase_nx = phase_q;
    if (fire) phase_nx = phase_nx + DN_P;
    if (take) phase_nx = phase_nx - UP_P;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= UP_P;
    else        phase_q <= phase_nx;
  end
endmodule

// File: rtl/rfr_tap_line.sv
module rfr_tap_line #(
  parameter int DW  = 16,
  parameter int NPH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] taps [NPH]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPH; i++) taps[i] <= '0;
    end else if (shift) begin
      taps[0] <= din;
      for (int i = 1; i < NPH; i++) taps[i] <= taps[i-1];
    end
  end
endmodule

// File: rtl/rfr_branch_mac.sv
module rfr_branch_mac #(
  parameter int UP    = 3,
  parameter int NTAPS = 12,
  parameter int NPH   = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int PW    = 3,
  parameter logic signed [CW-1:0] COEFS [NTAPS] = '{default: '0}
) (
  input  logic [PW-1:0]        phase,
  input  logic signed [DW-1:0] taps [NPH],
  output logic signed [DW-1:0] y
);
  localparam int PRW = DW + CW;
  localparam int AW  = PRW + $clog2(NPH) + 1;

  function automatic logic signed [CW-1:0] tap_coef(int k);
    return (k < NTAPS) ? COEFS[k] : '0;
  endfunction

  // floor by dropping CW fraction bits, wrap by keeping DW bits
  function automatic logic signed [DW-1:0] floor_wrap(logic signed [AW-1:0] a);
    return DW'(a >>> CW);
  endfunction

  logic signed [PRW-1:0] prod [NPH];
  logic signed [AW-1:0]  acc;

  generate
    for (genvar i = 0; i < NPH; i++) begin : g_branch
      logic signed [CW-1:0] c;
      always_comb begin
        c = '0;
        for (int p = 0; p < UP; p++)
          if (phase == PW'(p)) c = tap_coef(p + i * UP);
      end
      assign prod[i] = PRW'(taps[i]) * PRW'(c);
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPH; i++) acc = acc + AW'(prod[i]);
  end

  assign y = floor_wrap(acc);
endmodule

// File: rtl/rfr_out_hold.sv
module rfr_out_hold #(
  parameter int DW      = 16,
  parameter int USE_REQ = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic signed [DW-1:0] result,
  input  logic                 req_i,
  output logic                 hold_v,
  output logic                 drain,
  output logic signed [DW-1:0] data_o,
  output logic                 valid_o
);
  assign drain   = req_i || (USE_REQ == 0);
  assign valid_o = hold_v && drain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      data_o <= '0;
    end else if (fire) begin
      hold_v <= 1'b1;
      data_o <= result;
    end else if (drain) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_conv_fir.sv
module rate_conv_fir #(
  parameter int UP      = 3,
  parameter int DOWN    = 2,
  parameter int NTAPS   = 12,
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int USE_REQ = 0,
  parameter logic signed [CW-1:0] COEFS [NTAPS] = '{
    16'sd6000, -16'sd9000, 16'sd18000, 16'sd30000, 16'sd32000, 16'sd24000,
    16'sd24000, 16'sd32000, 16'sd30000, 16'sd18000, -16'sd9000, 16'sd6000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  input  logic                 req_i,
  output logic signed [DW-1:0] data_o,
  output logic                 valid_o
);
  localparam int NPH = rfr_pkg::ceil_div(NTAPS, UP);
  localparam int PW  = rfr_pkg::span_bits(UP + DOWN);

  // internal events, named for the bound checker
  logic                 fire;
  logic                 take;
  logic                 hold_v;
  logic                 drain;
  logic [PW-1:0]        phase_q;
  logic signed [DW-1:0] taps [NPH];
  logic signed [DW-1:0] mac_y;

  rfr_phase_ctrl #(.UP(UP), .DOWN(DOWN), .PW(PW), .USE_REQ(USE_REQ)) u_phase (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .hold_v(hold_v),
    .drain(drain), .ready_o(ready_o), .take(take), .fire(fire),
    .phase_q(phase_q));

  rfr_tap_line #(.DW(DW), .NPH(NPH)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(take), .din(data_i), .taps(taps));

  rfr_branch_mac #(.UP(UP), .NTAPS(NTAPS), .NPH(NPH), .DW(DW), .CW(CW),
                   .PW(PW), .COEFS(COEFS)) u_mac (
    .phase(phase_q), .taps(taps), .y(mac_y));

  rfr_out_hold #(.DW(DW), .USE_REQ(USE_REQ)) u_hold (
    .clk(clk), .rst_n(rst_n), .fire(fire), .result(mac_y), .req_i(req_i),
    .hold_v(hold_v), .drain(drain), .data_o(data_o), .valid_o(valid_o));
endmodule

// File: rtl/rate_conv_fir_chk.sv
module rate_conv_fir_chk #(
  parameter int UP      = 3,
  parameter int DOWN    = 2,
  parameter int PW      = 3,
  parameter int DW      = 16,
  parameter int USE_REQ = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] data_o,
  input logic                 hold_v,
  input logic                 fire,
  input logic                 take,
  input logic [PW-1:0]        phase_q
);
  a_r6_out_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_REQ != 0 && valid_o) |-> req_i);

  a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_REQ != 0 && hold_v && !req_i) |=> (hold_v && $stable(data_o)));

  a_r1_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PW'(UP + DOWN - 1));

  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !take) |=> (phase_q == $past(phase_q) + PW'(DOWN)));

  a_r3_take_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fire) |=> (phase_q == $past(phase_q) - PW'(UP)));

  a_r7_emit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_REQ == 0 && fire) |=> valid_o);
endmodule

bind rate_conv_fir rate_conv_fir_chk #(
  .UP(UP), .DOWN(DOWN), .PW(PW), .DW(DW), .USE_REQ(USE_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .valid_o(valid_o),
  .data_o(data_o), .hold_v(hold_v), .fire(fire), .take(take),
  .phase_q(phase_q));

// File: tb/rate_conv_fir_tb_top.sv
module rate_conv_fir_tb_top;
  localparam logic signed [15:0] HC [12] = '{
    16'sd6000, -16'sd9000, 16'sd18000, 16'sd30000, 16'sd32000, 16'sd24000,
    16'sd24000, 16'sd32000, 16'sd30000, 16'sd18000, -16'sd9000, 16'sd6000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic signed [15:0] dA = '0, dB = '0, dC = '0;
  logic vA = 1'b0, vB = 1'b0, vC = 1'b0, rqC = 1'b0;
  logic rdyA, rdyB, rdyC, voA, voB, voC;
  logic signed [15:0] oA, oB, oC;

  rate_conv_fir #(.UP(3), .DOWN(2), .NTAPS(12), .DW(16), .CW(16), .USE_REQ(0),
                  .COEFS(HC)) dut_i (
    .clk(clk), .rst_n(rst_n), .data_i(dA), .valid_i(vA), .ready_o(rdyA),
    .req_i(1'b0), .data_o(oA), .valid_o(voA));

  rate_conv_fir #(.UP(2), .DOWN(3), .NTAPS(12), .DW(16), .CW(16), .USE_REQ(0),
                  .COEFS(HC)) dut_dn_i (
    .clk(clk), .rst_n(rst_n), .data_i(dB), .valid_i(vB), .ready_o(rdyB),
    .req_i(1'b1), .data_o(oB), .valid_o(voB));

  rate_conv_fir #(.UP(3), .DOWN(2), .NTAPS(12), .DW(16), .CW(16), .USE_REQ(1),
                  .COEFS(HC)) dut_rq_i (
    .clk(clk), .rst_n(rst_n), .data_i(dC), .valid_i(vC), .ready_o(rdyC),
    .req_i(rqC), .data_o(oC), .valid_o(voC));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int xa[$], xb[$], xc[$];
  int ja = 0, jb = 0, jc = 0;
  int cntA = 0, cntB = 0;

  function automatic int val(int k);
    case ((k / 12) % 4)
      0:       return ((k * 2971) % 30000) - 15000;
      1:       return (k % 2) ? -32768 : 32767;
      2:       return 32767;
      default: return -((k % 5) + 1);
    endcase
  endfunction

  function automatic int xget(int which, int k);
    if (which == 0) return xa[k];
    if (which == 1) return xb[k];
    return xc[k];
  endfunction

  // zero-stuff by L, filter, keep every M-th: output j sits at stuffed index j*M
  function automatic int expect_y(int which, int j);
    int lr, mr, n, q, p, sz;
    longint s;
    logic signed [15:0] w;
    lr = (which == 1) ? 2 : 3;
    mr = (which == 1) ? 3 : 2;
    sz = (which == 0) ? xa.size() : (which == 1) ? xb.size() : xc.size();
    n = j * mr;
    q = n / lr;
    p = n % lr;
    if (q >= sz) return 99999;
    s = 0;
    for (int t = 0; t < 12; t++) begin
      if ((t % lr) == p && q - (t - p) / lr >= 0)
        s += longint'(HC[t]) * longint'(xget(which, q - (t - p) / lr));
    end
    s = s >>> 16;
    w = s[15:0];
    return int'(w);
  endfunction

  task automatic check_eq(string what, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      if (cyc < 80)       vA = (cyc % 2 == 0);
      else if (cyc < 200) vA = 1'b1;
      else                vA = 1'b0;
      dA  = 16'(val(xa.size()));
      vB  = (cyc < 120);
      dB  = 16'(val(xb.size() + 7));
      vC  = (cyc < 200);
      dC  = 16'(val(cyc * 5 + 3));
      rqC = (cyc >= 200) ? 1'b1 : (cyc >= 60 && cyc < 75) ? 1'b0 : (cyc % 3 != 0);
      #1;
      if (cyc == 0) begin
        // R2: reset state at the ports
        check_eq("R2 valid_o A after reset", int'(voA), 0);
        check_eq("R2 valid_o B after reset", int'(voB), 0);
        check_eq("R2 valid_o C after reset", int'(voC), 0);
        check_eq("R2 ready_o A after reset", int'(rdyA), 1);
        check_eq("R2 ready_o B after reset", int'(rdyB), 1);
        check_eq("R2 ready_o C after reset", int'(rdyC), 1);
      end
      // R4: paced source that never looks at ready
      if (cyc < 80 && vA) check_eq("R4 ready A at paced 3/2 input", int'(rdyA), 1);
      if (vB) check_eq("R4 ready B at every-cycle 2/3 input", int'(rdyB), 1);
      // R1/R8: every emitted sample against the model (R3: C drops samples)
      if (voA) begin check_eq("R1/R8 sample A", int'(oA), expect_y(0, ja)); ja++; end
      if (voB) begin check_eq("R1/R8 sample B", int'(oB), expect_y(1, jb)); jb++; end
      if (voC) begin check_eq("R1/R3 sample C", int'(oC), expect_y(2, jc)); jc++; end
      // R6: no output on a cycle without request
      if (voC && !rqC) check_eq("R6 valid_o C with req_i low", 1, 0);
      if (cyc >= 120 && cyc < 150 && voA) cntA++;
      if (cyc >= 60 && cyc < 90 && voB) cntB++;
      if (vA && rdyA) xa.push_back(int'(dA));
      if (vB && rdyB) xb.push_back(int'(dB));
      if (vC && rdyC) xc.push_back(int'(dC));
    end
    check_eq("R5 valid_o A count over 30 cycles", cntA, 30);
    check_eq("R7 valid_o B count over 30 cycles", cntB, 20);
    check_eq("R9 output count A", ja, (xa.size() * 3 + 1) / 2);
    check_eq("R9 output count B", jb, (xb.size() * 2 + 2) / 3);
    check_eq("R9 output count C", jc, (xc.size() * 3 + 1) / 2);
    check_eq("R3 C dropped some offered samples", int'(xc.size() < 200), 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule